// File: doc/BRIEF.md
# ADC Channel Scan and Alternate Sequencer

This block decides which of sixteen analog inputs an external converter samples next, runs one conversion at a time over a start/done handshake, and files each 12-bit result in a sixteen-slot result buffer. The A-side channel is either a fixed channel or, when scanning is on, each input picked out by a 16-bit select mask in turn, in ascending order. Alternate mode interleaves a fixed B-side channel after every A-side conversion. When scan and alternate are both on, every odd buffer slot holds the B-side input. Every enabled mask bit is converted, the highest one included.

A 4-bit field holds the number of conversions per interrupt minus one. When the last of those conversions completes, the block raises a one-cycle interrupt. The buffer write slot, the alternate phase and the scan position then all return to their start, so each interrupt period fills the buffer from slot 0 with the same channel order. Software reads results through a combinational read port.

Top module: `adc_scan_seq`

## Requirements
- R1: With scanning off, and outside a B-side phase, each requested conversion uses the fixed A channel `chan_a`.
- R2: With scanning on and a non-empty mask, A-side conversions step through the set mask bits in ascending channel order. This includes bit 15. The order wraps to the lowest set bit after the highest.
- R3: With scanning on and an all-zero mask, A-side conversions fall back to `chan_a`.
- R4: With alternate mode on, conversions at odd positions of an interrupt period use `chan_b`, and conversions at even positions use the A-side channel.
- R5: With scan and alternate both on, mask bits 3, 4 and 5, `chan_b` = 6 and `cnt_m1` = 7, the eight conversions of a period use channels 3,6,4,6,5,6,3,6 in that order.
- R6: The result of the k-th conversion of a period (k from 0) is written to buffer slot k. `rd_data` shows slot `rd_addr` in the same cycle.
- R7: `cnt_m1` holds the number of conversions per period minus one. `irq` is high for exactly one cycle, the cycle after the clock edge that accepts the last `conv_done` of the period.
- R8: After each interrupt, the write slot, the alternate phase and the scan position restart at zero, so the next period repeats the same channel order from slot 0.
- R9: While `enable` is low, `conv_start` stays low, `conv_done` is ignored and the buffer is left unchanged. Raising `enable` restarts the sequence from slot 0 and the first channel.
- R10: `conv_start` is high only while `enable` is high and no conversion is outstanding. It drops in the cycle after a start is accepted, and it stays low until the matching `conv_done`.
- R11: After reset, `irq` is low and every buffer slot reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the sequencer; low holds it idle at its start point |
| scan_en | input | 1 | A side follows the scan mask |
| alt_en | input | 1 | Interleave the B-side channel |
| scan_mask | input | 16 | One bit per A-side input included in the scan |
| chan_a | input | 4 | Fixed A-side channel |
| chan_b | input | 4 | Fixed B-side channel |
| cnt_m1 | input | 4 | Conversions per interrupt minus one |
| conv_start | output | 1 | Request a conversion on `conv_chan` |
| conv_chan | output | 4 | Channel for the requested conversion |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | 12 | Converter result |
| irq | output | 1 | One-cycle pulse at the end of a period |
| rd_addr | input | 4 | Buffer read slot |
| rd_data | output | 12 | Content of the slot at `rd_addr` |

## Verification
The sequencer is driven with several patterns. A sparse scan mask combined with alternate mode reproduces the interleaved 3,6,4,6,5,6,3,6 order. A mask holding only bits 0 and 15 shows whether the top bit is skipped at the wrap. A full mask over sixteen slots exercises every buffer slot. Fixed-channel runs, with and without alternate mode, separate the A and B selection. An empty mask separates the fallback path from scanning. A single-conversion period with alternate on shows that the phase restarts at each interrupt. Each pattern runs for two periods, which shows that the channel order repeats after an interrupt. Directed cases drop `enable` mid-period and pulse `conv_done` while disabled.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic {PH_A = 1'b0, PH_B = 1'b1} alt_phase_e;
endpackage

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NUM_CH = 16,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              scan_en,
  input  logic              alt_en,
  input  logic              phase_b,
  input  logic [NUM_CH-1:0] scan_mask,
  input  logic [CH_W-1:0]   chan_a,
  input  logic [CH_W-1:0]   chan_b,
  input  logic [CH_W-1:0]   scan_pos,
  output logic [CH_W-1:0]   pick_chan,
  output logic              pick_scan
);
  // First set mask bit at or above 'from', wrapping; MSB of result = found.
  function automatic logic [CH_W:0] first_from(input logic [NUM_CH-1:0] m,
                                               input logic [CH_W-1:0] from);
    logic [CH_W:0] r;
    int j;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      j = (int'(from) + i) % NUM_CH;
      if (m[j]) r = {1'b1, CH_W'(j)};
    end
    return r;
  endfunction

  logic [CH_W:0] hit;
  logic          use_b;
  logic          scan_live;

  assign hit       = first_from(scan_mask, scan_pos);
  assign use_b     = alt_en && phase_b;
  assign scan_live = scan_en && hit[CH_W];
  assign pick_scan = scan_live && !use_b;

  always_comb begin
    if (use_b)          pick_chan = chan_b;
    else if (scan_live) pick_chan = hit[CH_W-1:0];
    else                pick_chan = chan_a;
  end
endmodule

// File: rtl/adc_result_buf.sv
module adc_result_buf #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 16,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 slot_q[g] <= '0;
      else if (wr_en && (wr_ptr == PTR_W'(g)))    slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_addr];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int DEPTH  = 16,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             alt_en,
  input  logic             conv_done,
  input  logic [PTR_W-1:0] cnt_m1,
  input  logic [CH_W-1:0]  pick_chan,
  input  logic             pick_scan,
  output logic             conv_start,
  output logic             busy,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             phase_b,
  output logic [CH_W-1:0]  scan_pos,
  output logic             irq
);
  function automatic logic [CH_W-1:0] after(input logic [CH_W-1:0] c);
    return (int'(c) == NUM_CH - 1) ? '0 : c + 1'b1;
  endfunction

  alt_phase_e      phase_q;
  logic [CH_W-1:0] cur_chan;
  logic            cur_scan;
  logic            last;

  assign conv_start = enable && !busy;
  assign wr_en      = enable && busy && conv_done;
  assign last       = (wr_ptr == cnt_m1);
  assign phase_b    = (phase_q == PH_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; wr_ptr <= '0; phase_q <= PH_A; scan_pos <= '0;
      irq <= 1'b0; cur_chan <= '0; cur_scan <= 1'b0;
    end else if (!enable) begin
      busy <= 1'b0; wr_ptr <= '0; phase_q <= PH_A; scan_pos <= '0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (conv_start) begin
        busy     <= 1'b1;
        cur_chan <= pick_chan;
        cur_scan <= pick_scan;
      end else if (wr_en) begin
        busy <= 1'b0;
        if (last) begin
          wr_ptr <= '0; phase_q <= PH_A; scan_pos <= '0; irq <= 1'b1;
        end else begin
          wr_ptr  <= wr_ptr + 1'b1;
          phase_q <= (alt_en && !phase_b) ? PH_B : PH_A;
          if (cur_scan) scan_pos <= after(cur_chan);
        end
      end
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 12,
  parameter int DEPTH  = 16,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              scan_en,
  input  logic              alt_en,
  input  logic [NUM_CH-1:0] scan_mask,
  input  logic [CH_W-1:0]   chan_a,
  input  logic [CH_W-1:0]   chan_b,
  input  logic [PTR_W-1:0]  cnt_m1,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              irq,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic             busy;
  logic             wr_en;
  logic [PTR_W-1:0] wr_ptr;
  logic             phase_b;
  logic [CH_W-1:0]  scan_pos;
  logic             pick_scan;

  adc_chan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
    .scan_en(scan_en), .alt_en(alt_en), .phase_b(phase_b),
    .scan_mask(scan_mask), .chan_a(chan_a), .chan_b(chan_b),
    .scan_pos(scan_pos), .pick_chan(conv_chan), .pick_scan(pick_scan)
  );

  adc_seq_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .alt_en(alt_en),
    .conv_done(conv_done), .cnt_m1(cnt_m1), .pick_chan(conv_chan),
    .pick_scan(pick_scan), .conv_start(conv_start), .busy(busy),
    .wr_en(wr_en), .wr_ptr(wr_ptr), .phase_b(phase_b),
    .scan_pos(scan_pos), .irq(irq)
  );

  adc_result_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
    .wr_data(conv_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  parameter int PTR_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              scan_en,
  input logic              alt_en,
  input logic [NUM_CH-1:0] scan_mask,
  input logic [CH_W-1:0]   chan_a,
  input logic [CH_W-1:0]   chan_b,
  input logic              conv_start,
  input logic [CH_W-1:0]   conv_chan,
  input logic              conv_done,
  input logic              irq,
  input logic              busy,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic              phase_b
);
  p_fixed_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !scan_en && !(alt_en && phase_b)) |-> conv_chan == chan_a);

  p_scan_member_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && scan_en && (|scan_mask) && !(alt_en && phase_b)) |-> scan_mask[conv_chan]);

  p_empty_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && scan_en && (scan_mask == '0) && !(alt_en && phase_b)) |-> conv_chan == chan_a);

  p_alt_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && alt_en && phase_b) |-> conv_chan == chan_b);

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(conv_done && busy));

  p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (wr_ptr == '0 && !phase_b));

  p_idle_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !conv_start);

  p_start_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .scan_en(scan_en), .alt_en(alt_en),
  .scan_mask(scan_mask), .chan_a(chan_a), .chan_b(chan_b),
  .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
  .irq(irq), .busy(busy), .wr_ptr(wr_ptr), .phase_b(phase_b)
);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  typedef struct packed {
    logic        scan;
    logic        alt;
    logic [15:0] mask;
    logic [3:0]  a;
    logic [3:0]  b;
    logic [3:0]  cm1;
  } cfg_t;

  localparam int NROWS = 7;
  localparam cfg_t VEC [NROWS] = '{
    '{1'b1, 1'b1, 16'h0038, 4'd0,  4'd6, 4'd7},
    '{1'b1, 1'b0, 16'h8001, 4'd0,  4'd0, 4'd3},
    '{1'b0, 1'b1, 16'h0000, 4'd9,  4'd2, 4'd5},
    '{1'b1, 1'b0, 16'h0000, 4'd4,  4'd0, 4'd2},
    '{1'b1, 1'b0, 16'hFFFF, 4'd0,  4'd0, 4'd15},
    '{1'b0, 1'b1, 16'h0000, 4'd11, 4'd1, 4'd0},
    '{1'b0, 1'b0, 16'h0F0F, 4'd7,  4'd3, 4'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, scan_en = 1'b0, alt_en = 1'b0;
  logic [15:0] scan_mask = '0;
  logic [3:0]  chan_a = '0, chan_b = '0, cnt_m1 = '0, rd_addr = '0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic        conv_start, irq;
  logic [3:0]  conv_chan;
  logic [11:0] rd_data;

  int checks = 0;
  int errors = 0;
  int tag = 0;
  logic [11:0] got [16];

  always #10 clk = ~clk;

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scan_en(scan_en), .alt_en(alt_en),
    .scan_mask(scan_mask), .chan_a(chan_a), .chan_b(chan_b), .cnt_m1(cnt_m1),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_data(conv_data), .irq(irq), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string row_tag(input int r);
    case (r)
      0: return "R5";
      1: return "R2";
      2: return "R4";
      3: return "R3";
      4: return "R6";
      5: return "R8";
      default: return "R1";
    endcase
  endfunction

  // Expected channel of position i within a period, stated from the requirements.
  function automatic int exp_chan(input cfg_t c, input int i);
    int k, n, seen;
    if (c.alt && (i % 2 == 1)) return int'(c.b);
    k = c.alt ? i / 2 : i;
    if (!c.scan || c.mask == 16'h0) return int'(c.a);
    n = $countones(c.mask);
    k = k % n;
    seen = 0;
    for (int ch = 0; ch < 16; ch++) begin
      if (c.mask[ch]) begin
        if (seen == k) return ch;
        seen++;
      end
    end
    return -1;
  endfunction

  task automatic apply(input cfg_t c);
    scan_en = c.scan; alt_en = c.alt; scan_mask = c.mask;
    chan_a = c.a; chan_b = c.b; cnt_m1 = c.cm1;
  endtask

  // Entered just after a negedge; returns just after the negedge that ends done.
  task automatic do_conv(input int expc, input string req, input int slot);
    #1;
    check(conv_start === 1'b1, "R10", int'(conv_start), 1);
    check(int'(conv_chan) == expc, req, int'(conv_chan), expc);
    @(negedge clk);
    #1;
    check(conv_start === 1'b0, "R10", int'(conv_start), 0);
    tag++;
    conv_data = {conv_chan, 8'(tag)};
    got[slot] = conv_data;
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    #1;
  endtask

  task automatic check_buf(input int upto);
    for (int s = 0; s <= upto; s++) begin
      rd_addr = 4'(s);
      #1;
      check(rd_data == got[s], "R6", int'(rd_data), int'(got[s]));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    cfg_t c;
    logic [11:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R11 reset state
    check(irq === 1'b0, "R11", int'(irq), 0);
    for (int s = 0; s < 16; s++) begin
      rd_addr = 4'(s);
      #1;
      check(rd_data == 12'h0, "R11", int'(rd_data), 0);
    end
    check(conv_start === 1'b0, "R9", int'(conv_start), 0);

    // Table of configurations, two periods each
    for (int r = 0; r < NROWS; r++) begin
      c = VEC[r];
      @(negedge clk);
      apply(c);
      enable = 1'b1;
      for (int p = 0; p < 2; p++) begin
        for (int i = 0; i <= int'(c.cm1); i++) begin
          do_conv(exp_chan(c, i), (p == 0) ? row_tag(r) : "R8", i);
          check(irq === (i == int'(c.cm1)), "R7", int'(irq), int'(i == int'(c.cm1)));
        end
      end
      enable = 1'b0;
      @(negedge clk);
      check_buf(int'(c.cm1));
    end

    // R9: done while disabled is ignored
    rd_addr = 4'd0;
    #1;
    keep = rd_data;
    conv_done = 1'b1;
    conv_data = 12'hFFF;
    @(negedge clk);
    #1;
    check(conv_start === 1'b0, "R9", int'(conv_start), 0);
    conv_done = 1'b0;
    @(negedge clk);
    #1;
    check(rd_data == keep, "R9", int'(rd_data), int'(keep));

    // R9: dropping enable mid-period restarts from the first channel and slot 0
    c = VEC[0];
    apply(c);
    enable = 1'b1;
    for (int i = 0; i < 3; i++) do_conv(exp_chan(c, i), "R5", i);
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    for (int i = 0; i <= int'(c.cm1); i++) begin
      do_conv(exp_chan(c, i), "R9", i);
      check(irq === (i == int'(c.cm1)), "R7", int'(irq), int'(i == int'(c.cm1)));
    end
    enable = 1'b0;
    @(negedge clk);
    check_buf(int'(c.cm1));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule